// File: doc/BRIEF.md
# Paging Receiver Event Status and Host Interrupt Controller

This block collects event indications from a paging receiver into one status byte and drives a single interrupt line towards an external host. Some sources raise the interrupt as soon as they are latched. Others hold their request while the receiver is powered and release it when the receiver-enable level goes low. A freshly decoded call can also be released at the next sync word position, unless data-fail mode is active.

The host uses a small register port with an index register, read and write strobes, and 8-bit data. At index zero a read returns the status byte and a write loads the control byte. The control byte holds three interrupt masks and a selector for what status bit 6 watches. A status read clears the latched bits and the interrupt line, but it does not lose an event that arrives in the same cycle.

Top module: `pgr_status_irq`

## Requirements
- R1: After reset the status byte reads 0x00, the control byte is 0x00 (all sources enabled, bit 6 watching battery-low), and `irq_o` is at its inactive level. With the default `IRQ_ACT_HIGH`=1 the inactive level is 0.
- R2: Only index bits [3:0] select a register. An index of 0x10 behaves the same as index 0x00.
- R3: A write with a nonzero selected index leaves the control byte unchanged. A read with a nonzero selected index returns 0x00 and clears nothing.
- R4: Status bit positions: bit 2 call data, bit 3 SRAM pointers equal, bit 4 alert time-out, bit 5 out-of-range changed, bit 6 monitored level changed, bit 7 periodic time-out. Bits 1:0 read 0. Events in the same cycle set several bits together. A bit is visible one clock after its event.
- R5: Pointer-equal, alert and periodic events, and bit 6 when it watches receiver enable, raise the interrupt one clock after the event, whatever the receiver-enable level.
- R6: Call data, out-of-range change, and bit 6 when it watches battery-low raise the interrupt only when receiver enable is low. If receiver enable is high, the request waits and fires one clock after receiver enable goes low.
- R7: A pending call with receiver enable high fires at a sync word pulse, one clock later. It does not fire while data-fail mode is high.
- R8: A status read at index 0 clears the status byte and the interrupt one clock later. Events in the read cycle are kept and re-raise their bits and interrupt.
- R9: Control bits 5, 6 and 7 mask the interrupts of status bits 5, 6 and 7. A masked source still sets its status bit.
- R10: Control bit 2 selects the source of status bit 6: 0 means a battery-low level change, 1 means a receiver-enable level change. The unselected level has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_idx_we | input | 1 | Load index register from hst_wdata |
| hst_we | input | 1 | Write the selected register |
| hst_re | input | 1 | Read the selected register |
| hst_wdata | input | 8 | Host write data |
| hst_rdata | output | 8 | Host read data |
| ev_call | input | 1 | Call data available pulse |
| ev_ptr_eq | input | 1 | SRAM pointers equal pulse |
| ev_periodic | input | 1 | Periodic time-out pulse |
| ev_alert | input | 1 | Alert time-out pulse |
| ev_sync | input | 1 | Sync word position pulse |
| lv_oor | input | 1 | Out-of-range level |
| lv_batlow | input | 1 | Battery-low level |
| lv_rxe | input | 1 | Receiver enable level |
| lv_dfail | input | 1 | Data-fail mode level |
| irq_o | output | 1 | Interrupt to host, polarity set by IRQ_ACT_HIGH |

## Verification
A wrong pending flag shows up as an interrupt that arrives early while receiver enable is high, or as one that never comes when it falls. Either is visible on `irq_o` one clock after the edge of receiver enable or sync. A wrong status bit or mask appears in the next status read, and a stuck interrupt stays high one clock after that read. A lost event in the read cycle shows as a cleared status and a low interrupt right after the read.

// File: rtl/pgr_irq_pkg.sv
package pgr_irq_pkg;
  localparam int DATA_W   = 8;
  localparam int SEL_W    = 4;
  localparam int B_CALL   = 2;
  localparam int B_PTR    = 3;
  localparam int B_ALERT  = 4;
  localparam int B_OOR    = 5;
  localparam int B_MON    = 6;
  localparam int B_PER    = 7;
  localparam int C_MONSEL = 2;
  typedef logic [DATA_W-1:0] byte_t;
endpackage

// File: rtl/pgr_host_port.sv
module pgr_host_port
  import pgr_irq_pkg::*;
#(
  parameter int SEL_BITS = SEL_W
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idx_we,
  input  logic  we,
  input  logic  re,
  input  byte_t wdata,
  input  byte_t status,
  output byte_t rdata,
  output byte_t ctrl,
  output logic  stat_rd
);
  localparam logic [SEL_BITS-1:0] SEL_STAT = '0;

  byte_t idx_q, idx_d;
  byte_t ctrl_q, ctrl_d;
  logic  sel_zero;

  assign sel_zero = (idx_q[SEL_BITS-1:0] == SEL_STAT);

  always_comb begin
    idx_d  = idx_q;
    ctrl_d = ctrl_q;
    if (idx_we)
      idx_d = wdata;
    if (we && sel_zero)
      ctrl_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      ctrl_q <= '0;
    end else begin
      idx_q  <= idx_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign rdata   = sel_zero ? status : '0;
  assign stat_rd = re && sel_zero;
  assign ctrl    = ctrl_q;

  // R3
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !idx_we && idx_q[SEL_BITS-1:0] != SEL_STAT) |=> $stable(ctrl_q));
endmodule

// File: rtl/pgr_lvl_edge.sv
module pgr_lvl_edge #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] chg
);
  logic [N-1:0] prev_q;
  logic         armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      prev_q  <= lvl;
      armed_q <= 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_det
    assign chg[i] = armed_q && (lvl[i] != prev_q[i]);
  end
endmodule

// File: rtl/pgr_irq_core.sv
module pgr_irq_core
  import pgr_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  byte_t ctrl,
  input  logic  stat_rd,
  input  logic  ev_call,
  input  logic  ev_ptr_eq,
  input  logic  ev_periodic,
  input  logic  ev_alert,
  input  logic  ev_sync,
  input  logic  oor_chg,
  input  logic  bat_chg,
  input  logic  rxe_chg,
  input  logic  rxe,
  input  logic  dfail,
  output byte_t status,
  output logic  irq
);
  byte_t stat_q, stat_d, set_vec;
  logic  irq_q, irq_d;
  logic  callp_q, callp_d, othp_q, othp_d;
  logic  mon_chg, mon_rxe;
  logic  imm, def_oth, cp, op, fire_def, fire_sync;

  assign mon_rxe = ctrl[C_MONSEL];
  assign mon_chg = mon_rxe ? rxe_chg : bat_chg;

  always_comb begin
    set_vec         = '0;
    set_vec[B_CALL]  = ev_call;
    set_vec[B_PTR]   = ev_ptr_eq;
    set_vec[B_ALERT] = ev_alert;
    set_vec[B_OOR]   = oor_chg;
    set_vec[B_MON]   = mon_chg;
    set_vec[B_PER]   = ev_periodic;
  end

  assign imm = ev_ptr_eq | ev_alert
             | (ev_periodic & ~ctrl[B_PER])
             | (mon_chg & mon_rxe & ~ctrl[B_MON]);

  assign def_oth = (oor_chg & ~ctrl[B_OOR])
                 | (mon_chg & ~mon_rxe & ~ctrl[B_MON]);

  assign cp = callp_q & ~stat_rd;
  assign op = othp_q & ~stat_rd;

  assign fire_def  = ~rxe & (cp | op | ev_call | def_oth);
  assign fire_sync = rxe & ev_sync & ~dfail & (cp | ev_call);

  always_comb begin
    stat_d  = (stat_rd ? '0 : stat_q) | set_vec;
    irq_d   = (irq_q & ~stat_rd) | imm | fire_def | fire_sync;
    callp_d = (cp | ev_call) & rxe & ~fire_sync;
    othp_d  = (op | def_oth) & rxe;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= '0;
      irq_q   <= 1'b0;
      callp_q <= 1'b0;
      othp_q  <= 1'b0;
    end else begin
      stat_q  <= stat_d;
      irq_q   <= irq_d;
      callp_q <= callp_d;
      othp_q  <= othp_d;
    end
  end

  assign status = stat_q;
  assign irq    = irq_q;

  // R6
  no_pend_rx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rxe |=> !(callp_q || othp_q));
  // R8
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !ev_call && !ev_ptr_eq && !ev_periodic && !ev_alert
     && !oor_chg && !bat_chg && !rxe_chg) |=> (stat_q == '0 && !irq_q));
  // R5
  ptr_imm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ptr_eq |=> (irq_q && stat_q[B_PTR]));
  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> (stat_q != '0 || $past(stat_q) != '0));
  // R9
  per_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_periodic && ctrl[B_PER] && !irq_q && !imm && !fire_def && !fire_sync)
      |=> (!irq_q && stat_q[B_PER]));
endmodule

// File: rtl/pgr_status_irq.sv
module pgr_status_irq
  import pgr_irq_pkg::*;
#(
  parameter bit IRQ_ACT_HIGH = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hst_idx_we,
  input  logic       hst_we,
  input  logic       hst_re,
  input  logic [7:0] hst_wdata,
  output logic [7:0] hst_rdata,
  input  logic       ev_call,
  input  logic       ev_ptr_eq,
  input  logic       ev_periodic,
  input  logic       ev_alert,
  input  logic       ev_sync,
  input  logic       lv_oor,
  input  logic       lv_batlow,
  input  logic       lv_rxe,
  input  logic       lv_dfail,
  output logic       irq_o
);
  localparam int NLVL = 3;

  byte_t        ctrl, status;
  logic         stat_rd, irq_raw;
  logic [NLVL-1:0] lvl_vec, chg_vec;

  assign lvl_vec = {lv_rxe, lv_batlow, lv_oor};

  pgr_host_port #(.SEL_BITS(SEL_W)) u_port (
    .clk(clk), .rst_n(rst_n), .idx_we(hst_idx_we), .we(hst_we), .re(hst_re),
    .wdata(hst_wdata), .status(status), .rdata(hst_rdata), .ctrl(ctrl),
    .stat_rd(stat_rd)
  );

  pgr_lvl_edge #(.N(NLVL)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl_vec), .chg(chg_vec)
  );

  pgr_irq_core u_core (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .stat_rd(stat_rd),
    .ev_call(ev_call), .ev_ptr_eq(ev_ptr_eq), .ev_periodic(ev_periodic),
    .ev_alert(ev_alert), .ev_sync(ev_sync),
    .oor_chg(chg_vec[0]), .bat_chg(chg_vec[1]), .rxe_chg(chg_vec[2]),
    .rxe(lv_rxe), .dfail(lv_dfail), .status(status), .irq(irq_raw)
  );

  if (IRQ_ACT_HIGH) begin : g_pol_hi
    assign irq_o = irq_raw;
  end else begin : g_pol_lo
    assign irq_o = ~irq_raw;
  end
endmodule

// File: tb/sim_pgr_status_irq.sv
module sim_pgr_status_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic idx_we = 0, we = 0, re = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic call = 0, ptr = 0, per = 0, alrt = 0, sync = 0;
  logic oor = 0, bat = 0, rxe = 1, dfail = 0;
  logic irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pgr_status_irq u0 (
    .clk(clk), .rst_n(rst_n), .hst_idx_we(idx_we), .hst_we(we), .hst_re(re),
    .hst_wdata(wdata), .hst_rdata(rdata), .ev_call(call), .ev_ptr_eq(ptr),
    .ev_periodic(per), .ev_alert(alrt), .ev_sync(sync), .lv_oor(oor),
    .lv_batlow(bat), .lv_rxe(rxe), .lv_dfail(dfail), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_idx(input logic [7:0] v);
    idx_we = 1; wdata = v; tick(); idx_we = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    we = 1; wdata = v; tick(); we = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    re = 1; #1 v = rdata; tick(); re = 0;
  endtask

  task automatic pulse(input logic [4:0] m);
    {sync, alrt, per, ptr, call} = m; tick(); {sync, alrt, per, ptr, call} = '0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(v); chk("R1 status", v, 8'h00);
  endtask

  task automatic t_index();
    logic [7:0] v;
    set_idx(8'h10);
    pulse(5'b00010);
    chk("R5 ptr irq", {7'd0, irq}, 8'h01);
    rd(v); chk("R2 R4 ptr bit via idx 10", v, 8'h08);
    chk("R8 irq cleared", {7'd0, irq}, 8'h00);
    rd(v); chk("R8 status cleared", v, 8'h00);
    set_idx(8'h00);
  endtask

  task automatic t_immediate();
    logic [7:0] v;
    pulse(5'b01000);
    chk("R5 alert irq rxe high", {7'd0, irq}, 8'h01);
    rd(v); chk("R4 alert bit", v, 8'h10);
    pulse(5'b00100);
    chk("R5 periodic irq", {7'd0, irq}, 8'h01);
    rd(v); chk("R4 periodic bit", v, 8'h80);
    pulse(5'b01010);
    rd(v); chk("R4 multi bits", v, 8'h18);
  endtask

  task automatic t_defer();
    logic [7:0] v;
    pulse(5'b00001);
    chk("R6 call waits rxe high", {7'd0, irq}, 8'h00);
    rxe = 0; tick();
    chk("R6 call fires rxe low", {7'd0, irq}, 8'h01);
    rd(v); chk("R4 call bit", v, 8'h04);
    pulse(5'b00001);
    chk("R6 call immediate rxe low", {7'd0, irq}, 8'h01);
    rd(v);
    rxe = 1; tick();
    oor = 1; tick();
    chk("R6 oor waits", {7'd0, irq}, 8'h00);
    rd(v); chk("R4 oor bit", v, 8'h20);
    rxe = 0; tick();
    chk("R6 oor request dropped by read", {7'd0, irq}, 8'h00);
    rxe = 1; tick();
    oor = 0; tick();
    rxe = 0; tick();
    chk("R6 oor fires after rxe low", {7'd0, irq}, 8'h01);
    rd(v); chk("R6 oor bit", v, 8'h20);
    rxe = 1; tick();
  endtask

  task automatic t_sync();
    logic [7:0] v;
    dfail = 1;
    pulse(5'b00001);
    pulse(5'b10000);
    chk("R7 no fire in data-fail", {7'd0, irq}, 8'h00);
    dfail = 0;
    pulse(5'b10000);
    chk("R7 fire at sync", {7'd0, irq}, 8'h01);
    rd(v); chk("R7 call bit", v, 8'h04);
    pulse(5'b10000);
    chk("R7 no repeat", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_mask();
    logic [7:0] v;
    wr(8'hE0);
    pulse(5'b00100);
    chk("R9 periodic masked", {7'd0, irq}, 8'h00);
    rxe = 0; tick();
    oor = 1; bat = 1; tick();
    chk("R9 oor bat masked", {7'd0, irq}, 8'h00);
    rd(v); chk("R9 bits still set", v, 8'he0);
    oor = 0; bat = 0; rxe = 1; tick();
    rd(v);
    wr(8'h00);
  endtask

  task automatic t_ignore();
    logic [7:0] v;
    set_idx(8'h0B);
    wr(8'hE0);
    rd(v); chk("R3 nonzero index reads zero", v, 8'h00);
    pulse(5'b00100);
    chk("R3 mask not written", {7'd0, irq}, 8'h01);
    rd(v); chk("R3 read idx B no clear", {7'd0, irq}, 8'h01);
    set_idx(8'h00);
    rd(v); chk("R3 status kept", v, 8'h80);
  endtask

  task automatic t_select();
    logic [7:0] v;
    wr(8'h04);
    rxe = 0; tick();
    chk("R10 rxe fall irq", {7'd0, irq}, 8'h01);
    rd(v); chk("R10 rxe bit", v, 8'h40);
    rxe = 1; tick();
    chk("R10 rxe rise irq with rxe high", {7'd0, irq}, 8'h01);
    rd(v);
    bat = 1; tick(); bat = 0; tick();
    rd(v); chk("R10 bat ignored in rxe mode", v, 8'h00);
    wr(8'h00);
    rxe = 0; tick();
    rd(v); chk("R10 rxe ignored in bat mode", v, 8'h00);
    rxe = 1; tick();
    bat = 1; tick();
    chk("R6 bat waits", {7'd0, irq}, 8'h00);
    rxe = 0; tick();
    chk("R6 bat fires", {7'd0, irq}, 8'h01);
    rd(v); chk("R10 bat bit", v, 8'h40);
    bat = 0; tick(); rd(v);
    rxe = 1; tick();
  endtask

  task automatic t_same();
    logic [7:0] v;
    pulse(5'b00010);
    re = 1; alrt = 1; #1 v = rdata; tick(); re = 0; alrt = 0;
    chk("R8 read returns old", v, 8'h08);
    chk("R8 same-cycle irq kept", {7'd0, irq}, 8'h01);
    rd(v); chk("R8 same-cycle bit kept", v, 8'h10);
    chk("R8 final clear", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_index();
    t_immediate();
    t_defer();
    t_sync();
    t_mask();
    t_ignore();
    t_select();
    t_same();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule